// File: doc/BRIEF.md
# Sixteen-Word Permutation Round

This block applies one full permutation round to sixteen 64-bit words. The words form four groups of four lanes, called a, b, c and d. A round has two halves. The column half runs four mixes, one per lane index. The diagonal half then runs four more mixes on the column results. In the diagonal half, each mix takes its a, b, c and d words from lanes that sit one step further along for each group. Each mix is a chain of multiply-add and xor-rotate updates. The multiply takes the low halves of two words, and the product is doubled before it is added.

The design uses four mixing units side by side, one per lane. They share a small sequencer that performs one quarter of a mix per cycle, so a round takes eight cycles after the start is accepted. The diagonal half uses the same four units. On their way into the units, the b, c and d groups are rotated by one, two and three lanes. On the way back to the word register, they are rotated back by the same amounts. Start captures a 1024-bit input. Done pulses once when the round is finished, and the output then holds until the next accepted start.

Top module: `perm_round16`

## Requirements
- R1: Word k (k = 0..15) sits in bits [64k+63:64k] of both the input and the output vectors. Words 0..3 are a0..a3, words 4..7 are b0..b3, words 8..11 are c0..c3 and words 12..15 are d0..d3.
- R2: One mix of (a,b,c,d) applies four update pairs in order. The function f(x,y) is x + y + 2·lo(x)·lo(y) mod 2^64, where lo is the low 32 bits, and ror is a right rotation. The pairs are:
  - a = f(a,b), then d = ror(d^a, 32)
  - c = f(c,d), then b = ror(b^c, 24)
  - a = f(a,b), then d = ror(d^a, 16)
  - c = f(c,d), then b = ror(b^c, 63)
- R3: The column half mixes (a_i, b_i, c_i, d_i) for i = 0..3. Four clock edges after the edge that accepts start, the output shows exactly the column-half result.
- R4: The diagonal half mixes (a0,b1,c2,d3), (a1,b2,c3,d0), (a2,b3,c0,d1) and (a3,b0,c1,d2). It works on the column-half results, and its outputs go back to their original word positions.
- R5: Done is high for exactly one cycle, directly after the eighth edge following the accepting edge. At that point the output holds the full round result.
- R6: While idle and with start low, the output does not change, whatever the input vector does.
- R7: A start seen while a round is in progress is ignored. The round in flight finishes with its own result and timing, and no extra done follows.
- R8: After reset the output is all zeros, done is low and the block is idle.
- R9: A start in the cycle where done is high is accepted, and a new round begins at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begins a round when the block is idle |
| words_i | input | 1024 | Sixteen input words, captured when start is accepted |
| words_o | output | 1024 | Working words; the round result once done has pulsed |
| done_o | output | 1 | One-cycle pulse when the round is complete |

## Verification
The mix chain spreads any error across words within a step or two. A wrong lane routing, rotation amount or update order therefore corrupts several output words at the single done sample. A misrouted column mix shows up even earlier, in the snapshot taken four edges after start. A sequencer that counts wrong shows up as done arriving a cycle off, done repeating, or a second start disturbing the round in flight. The bench sweeps a nonzero word through every position and also runs dense and random vectors. This pins down the placement of each lane group in both halves.

// File: rtl/perm_round_pkg.sv
package perm_round_pkg;
    localparam int GROUPS      = 4;
    localparam int GROUP_LANES = 4;
    localparam int QUARTERS    = 4;

    typedef enum logic [0:0] {
        STEP_COL  = 1'b0,
        STEP_DIAG = 1'b1
    } step_e;
endpackage

// File: rtl/perm_lane_rot.sv
module perm_lane_rot #(
    parameter int WORD_W = 64,
    parameter int LANES  = 4,
    parameter int SHIFT  = 1
) (
    input  logic [LANES*WORD_W-1:0] din,
    output logic [LANES*WORD_W-1:0] dout
);
    // output lane i takes input lane (i + SHIFT) mod LANES
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int SRC = (i + SHIFT) % LANES;
        assign dout[i*WORD_W +: WORD_W] = din[SRC*WORD_W +: WORD_W];
    end
endmodule

// File: rtl/perm_mix_unit.sv
module perm_mix_unit #(
    parameter int WORD_W = 64
) (
    input  logic [1:0]        phase_i,
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    input  logic [WORD_W-1:0] c_i,
    input  logic [WORD_W-1:0] d_i,
    output logic [WORD_W-1:0] a_o,
    output logic [WORD_W-1:0] b_o,
    output logic [WORD_W-1:0] c_o,
    output logic [WORD_W-1:0] d_o
);
    localparam int HALF  = WORD_W / 2;
    localparam int ROT_A = WORD_W / 2;
    localparam int ROT_B = (3 * WORD_W) / 8;
    localparam int ROT_C = WORD_W / 4;
    localparam int ROT_D = WORD_W - 1;

    function automatic logic [WORD_W-1:0] mul_add(input logic [WORD_W-1:0] x,
                                                  input logic [WORD_W-1:0] y);
        logic [WORD_W-1:0] prod;
        prod = {{HALF{1'b0}}, x[HALF-1:0]} * {{HALF{1'b0}}, y[HALF-1:0]};
        return x + y + (prod << 1);
    endfunction

    function automatic logic [WORD_W-1:0] rot_r(input logic [WORD_W-1:0] v, input int sh);
        return (v >> sh) | (v << (WORD_W - sh));
    endfunction

    logic [WORD_W-1:0] acc;
    logic [WORD_W-1:0] mixed;

    // even quarter: update a from b, fold into d; odd quarter: update c from d, fold into b
    always_comb begin
        a_o = a_i;
        b_o = b_i;
        c_o = c_i;
        d_o = d_i;
        if (!phase_i[0]) begin
            acc   = mul_add(a_i, b_i);
            mixed = d_i ^ acc;
            a_o   = acc;
            d_o   = phase_i[1] ? rot_r(mixed, ROT_C) : rot_r(mixed, ROT_A);
        end else begin
            acc   = mul_add(c_i, d_i);
            mixed = b_i ^ acc;
            c_o   = acc;
            b_o   = phase_i[1] ? rot_r(mixed, ROT_D) : rot_r(mixed, ROT_B);
        end
    end
endmodule

// File: rtl/perm_round16.sv
module perm_round16
    import perm_round_pkg::*;
#(
    parameter int WORD_W = 64
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      start_i,
    input  logic [GROUPS*GROUP_LANES*WORD_W-1:0]      words_i,
    output logic [GROUPS*GROUP_LANES*WORD_W-1:0]      words_o,
    output logic                                      done_o
);
    localparam int GW    = GROUP_LANES * WORD_W;
    localparam int BW    = GROUPS * GW;
    localparam int PH_W  = $clog2(QUARTERS);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(QUARTERS - 1);

    typedef struct packed {
        logic [BW-1:0]   words;
        logic            busy;
        logic            done;
        step_e           step;
        logic [PH_W-1:0] phase;
    } state_t;

    state_t st_d, st_q;
    logic   accept_d;

    // ---- group views of the working words ----
    logic [GW-1:0] grp_a_q, grp_b_q, grp_c_q, grp_d_q;
    assign grp_a_q = st_q.words[0*GW +: GW];
    assign grp_b_q = st_q.words[1*GW +: GW];
    assign grp_c_q = st_q.words[2*GW +: GW];
    assign grp_d_q = st_q.words[3*GW +: GW];

    // ---- diagonalise: b by 1, c by 2, d by 3 lanes ----
    logic [GW-1:0] b_diag, c_diag, d_diag;
    perm_lane_rot #(.WORD_W(WORD_W), .LANES(GROUP_LANES), .SHIFT(1)) u_rot_b_in (.din(grp_b_q), .dout(b_diag));
    perm_lane_rot #(.WORD_W(WORD_W), .LANES(GROUP_LANES), .SHIFT(2)) u_rot_c_in (.din(grp_c_q), .dout(c_diag));
    perm_lane_rot #(.WORD_W(WORD_W), .LANES(GROUP_LANES), .SHIFT(3)) u_rot_d_in (.din(grp_d_q), .dout(d_diag));

    logic          in_diag;
    logic [GW-1:0] mix_b_in, mix_c_in, mix_d_in;
    assign in_diag  = (st_q.step == STEP_DIAG);
    assign mix_b_in = in_diag ? b_diag : grp_b_q;
    assign mix_c_in = in_diag ? c_diag : grp_c_q;
    assign mix_d_in = in_diag ? d_diag : grp_d_q;

    // ---- four mixing units, one per lane ----
    logic [GW-1:0] mix_a_out, mix_b_out, mix_c_out, mix_d_out;
    for (genvar ln = 0; ln < GROUP_LANES; ln++) begin : g_mix
        perm_mix_unit #(.WORD_W(WORD_W)) u_mix (
            .phase_i (st_q.phase),
            .a_i     (grp_a_q [ln*WORD_W +: WORD_W]),
            .b_i     (mix_b_in[ln*WORD_W +: WORD_W]),
            .c_i     (mix_c_in[ln*WORD_W +: WORD_W]),
            .d_i     (mix_d_in[ln*WORD_W +: WORD_W]),
            .a_o     (mix_a_out[ln*WORD_W +: WORD_W]),
            .b_o     (mix_b_out[ln*WORD_W +: WORD_W]),
            .c_o     (mix_c_out[ln*WORD_W +: WORD_W]),
            .d_o     (mix_d_out[ln*WORD_W +: WORD_W])
        );
    end

    // ---- undo diagonalisation on the way back ----
    logic [GW-1:0] b_undo, c_undo, d_undo;
    perm_lane_rot #(.WORD_W(WORD_W), .LANES(GROUP_LANES), .SHIFT(GROUP_LANES-1)) u_rot_b_out (.din(mix_b_out), .dout(b_undo));
    perm_lane_rot #(.WORD_W(WORD_W), .LANES(GROUP_LANES), .SHIFT(GROUP_LANES-2)) u_rot_c_out (.din(mix_c_out), .dout(c_undo));
    perm_lane_rot #(.WORD_W(WORD_W), .LANES(GROUP_LANES), .SHIFT(GROUP_LANES-3)) u_rot_d_out (.din(mix_d_out), .dout(d_undo));

    logic [BW-1:0] words_back;
    assign words_back = in_diag ? {d_undo, c_undo, b_undo, mix_a_out}
                                : {mix_d_out, mix_c_out, mix_b_out, mix_a_out};

    // ---- next-state logic ----
    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        accept_d  = start_i && !st_q.busy;
        if (accept_d) begin
            st_d.words = words_i;
            st_d.busy  = 1'b1;
            st_d.step  = STEP_COL;
            st_d.phase = '0;
        end else if (st_q.busy) begin
            st_d.words = words_back;
            st_d.phase = st_q.phase + 1'b1;
            if (st_q.phase == PH_LAST) begin
                if (st_q.step == STEP_COL) begin
                    st_d.step = STEP_DIAG;
                end else begin
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{words: '0, busy: 1'b0, done: 1'b0, step: STEP_COL, phase: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign words_o = st_q.words;
    assign done_o  = st_q.done;

    // ---- assertions ----
    a_r5_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r5_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(accept_d, 9));

    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && !start_i) |=> $stable(words_o));

    a_r7_round_runs_through: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !(st_q.step == STEP_DIAG && st_q.phase == PH_LAST)) |=> (st_q.busy && !done_o));
endmodule

// File: tb/sim_perm_round16.sv
module sim_perm_round16;
    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [1023:0] words_i = '0;
    logic [1023:0] words_o;
    logic          done_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    perm_round16 #(.WORD_W(64)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .words_i(words_i), .words_o(words_o), .done_o(done_o)
    );

    // ---------------- reference model ----------------
    function automatic logic [63:0] fadd(input logic [63:0] x, input logic [63:0] y);
        logic [63:0] p;
        p = {32'b0, x[31:0]} * {32'b0, y[31:0]};
        return x + y + p + p;
    endfunction

    function automatic logic [63:0] rr(input logic [63:0] x, input int n);
        return (x >> n) | (x << (64 - n));
    endfunction

    function automatic logic [255:0] gmix(input logic [63:0] a0, input logic [63:0] b0,
                                          input logic [63:0] c0, input logic [63:0] d0);
        logic [63:0] a, b, c, d;
        a = a0; b = b0; c = c0; d = d0;
        a = fadd(a, b); d = rr(d ^ a, 32);
        c = fadd(c, d); b = rr(b ^ c, 24);
        a = fadd(a, b); d = rr(d ^ a, 16);
        c = fadd(c, d); b = rr(b ^ c, 63);
        return {a, b, c, d};
    endfunction

    function automatic logic [1023:0] ref_round(input logic [1023:0] v, input bit with_diag);
        logic [63:0]  w [16];
        logic [255:0] g;
        logic [1023:0] r;
        for (int k = 0; k < 16; k++) w[k] = v[64*k +: 64];
        for (int i = 0; i < 4; i++) begin
            g = gmix(w[i], w[4+i], w[8+i], w[12+i]);
            w[i] = g[255:192]; w[4+i] = g[191:128]; w[8+i] = g[127:64]; w[12+i] = g[63:0];
        end
        if (with_diag) begin
            for (int i = 0; i < 4; i++) begin
                int ib, ic, id;
                ib = 4 + (i + 1) % 4;
                ic = 8 + (i + 2) % 4;
                id = 12 + (i + 3) % 4;
                g = gmix(w[i], w[ib], w[ic], w[id]);
                w[i] = g[255:192]; w[ib] = g[191:128]; w[ic] = g[127:64]; w[id] = g[63:0];
            end
        end
        for (int k = 0; k < 16; k++) r[64*k +: 64] = w[k];
        return r;
    endfunction

    function automatic logic [1023:0] rand_vec();
        logic [1023:0] v;
        for (int k = 0; k < 32; k++) v[32*k +: 32] = $urandom;
        return v;
    endfunction

    // ---------------- checking ----------------
    task automatic check_vec(input string req, input logic [1023:0] act, input logic [1023:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // drive a start at the current negedge and check the whole round
    task automatic run_round(input logic [1023:0] v, input string tag);
        logic [1023:0] col_exp, full_exp;
        col_exp  = ref_round(v, 1'b0);
        full_exp = ref_round(v, 1'b1);
        start_i = 1'b1;
        words_i = v;
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            if (k == 1) start_i = 1'b0;
            if (k == 5) check_vec({"R3 column half ", tag}, words_o, col_exp);
            if (k == 8) check_bit({"R5 done early ", tag}, done_o, 1'b0);
            if (k == 9) begin
                check_bit({"R5 done pulse ", tag}, done_o, 1'b1);
                check_vec({"R4 R2 round result ", tag}, words_o, full_exp);
            end
            if (k == 10) check_bit({"R5 done width ", tag}, done_o, 1'b0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [1023:0] v1, v2, held;
        repeat (3) @(negedge clk);
        // R8 reset state
        check_vec("R8 reset output", words_o, '0);
        check_bit("R8 reset done", done_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 zero maps to zero
        run_round('0, "zeros");
        run_round({1024{1'b1}}, "ones");

        // R1 position sweep: one nonzero word in each slot
        for (int k = 0; k < 16; k++) begin
            logic [1023:0] v;
            v = '0;
            v[64*k +: 64] = 64'h0123_4567_89ab_cdef ^ 64'(k);
            run_round(v, $sformatf("R1 slot %0d", k));
        end

        // dense patterns
        for (int k = 0; k < 8; k++) run_round(rand_vec(), $sformatf("rand %0d", k));

        // R6 idle hold
        held = words_o;
        for (int k = 0; k < 6; k++) begin
            words_i = rand_vec();
            @(negedge clk);
            check_vec("R6 idle hold", words_o, held);
            check_bit("R6 no done while idle", done_o, 1'b0);
        end

        // R7 start while busy ignored
        v1 = rand_vec();
        v2 = rand_vec();
        start_i = 1'b1;
        words_i = v1;
        for (int k = 1; k <= 13; k++) begin
            @(negedge clk);
            if (k == 1) start_i = 1'b0;
            if (k == 3) begin start_i = 1'b1; words_i = v2; end
            if (k == 5) start_i = 1'b0;
            if (k == 9) begin
                check_bit("R7 done timing", done_o, 1'b1);
                check_vec("R7 result of first start", words_o, ref_round(v1, 1'b1));
            end
            if (k > 9) check_bit("R7 no extra done", done_o, 1'b0);
        end

        // R9 back-to-back start in the done cycle
        v1 = rand_vec();
        v2 = rand_vec();
        start_i = 1'b1;
        words_i = v1;
        for (int k = 1; k <= 18; k++) begin
            @(negedge clk);
            if (k == 1) start_i = 1'b0;
            if (k == 9) begin
                check_vec("R9 first result", words_o, ref_round(v1, 1'b1));
                start_i = 1'b1;
                words_i = v2;
            end
            if (k == 10) start_i = 1'b0;
            if (k == 18) begin
                check_bit("R9 second done", done_o, 1'b1);
                check_vec("R9 second result", words_o, ref_round(v2, 1'b1));
            end
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule